// File: doc/BRIEF.md
# 64-bit Integer Execution Unit with Scaled Add

This block is the integer arithmetic and logic stage of a wide datapath. Each cycle it may accept one operation with two register operands (index and value), or one register operand and a sign-extended immediate. It computes a sum, difference, scaled sum, bitwise result or shift, and returns the 64-bit result one clock later. With the result it gives a destination index and a write strobe, ready for a register file write port.

The write strobe is gated by a qualifying predicate bit, so a false predicate cancels the operation with no side effect. Source index 0 always supplies the value zero, whatever sits on its value bus. A destination index of 0 never produces a write. A single option bit adds one extra to an add or takes one extra away from a subtract. A 2-bit scale field picks a left shift of 1 to 4 places for the scaled add. Register-count shifts saturate when the count is above 63.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `out_wr_en` and `out_wr_data` are 0 after that edge.
- R2: Op code 0 (add) yields A + B, plus 1 more when `in_adj` is 1. With `in_use_imm` set, A is the full 14-bit `in_imm` sign-extended to 64 bits.
- R3: Op code 1 (subtract) yields A − B, minus 1 more when `in_adj` is 1. With `in_use_imm` set, A is `in_imm[7:0]` sign-extended, and `in_imm[13:8]` has no effect.
- R4: Op code 2 (scaled add) yields (A << (`in_scale`+1)) + B, so `in_scale` 0..3 shifts by 1..4. Here `in_adj` and `in_use_imm` have no effect and A is always the register operand.
- R5: Op codes 3, 4, 5 and 6 yield A & B, A | B, A ^ B and A & ~B. With `in_use_imm` set, A is `in_imm[7:0]` sign-extended.
- R6: Op code 7 shifts the register operand A left. The count is `in_imm[5:0]` (unsigned) when `in_use_imm` is set, otherwise the value of B. A register count above 63 yields 0.
- R7: Op code 8 (arithmetic) and op code 9 (logical) shift A right, with the count taken as in R6. Above 63, op 8 yields 64 copies of A's bit 63 and op 9 yields 0.
- R8: `out_wr_en` is 1 only for an operation with `in_valid`=1 and `in_qp`=1. Op codes 10 to 15 never write.
- R9: A source index of 0 supplies the value 0 regardless of its value bus. A destination index of 0 never sets `out_wr_en`.
- R10: The result, `out_wr_idx` = `in_dst_idx` and `out_wr_en` appear after the first rising edge following the sampled inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_qp | input | 1 | Qualifying predicate; 0 cancels the write |
| in_op | input | 4 | Operation code |
| in_adj | input | 1 | Extra +1 for add, extra −1 for subtract |
| in_use_imm | input | 1 | Take the immediate instead of a register operand |
| in_imm | input | IMM_W (14) | Immediate field |
| in_scale | input | SCALE_W (2) | Scaled-add shift minus one |
| in_a_idx | input | IDX_W (7) | First source index |
| in_a_val | input | DATA_W (64) | First source value |
| in_b_idx | input | IDX_W (7) | Second source index |
| in_b_val | input | DATA_W (64) | Second source value |
| in_dst_idx | input | IDX_W (7) | Destination index |
| out_wr_en | output | 1 | Registered write strobe |
| out_wr_idx | output | IDX_W (7) | Registered destination index |
| out_wr_data | output | DATA_W (64) | Registered result |

## Verification
On every cycle, the assertions check that a false predicate or a zero destination never leads to a write. They also check that a register-count left shift or logical right shift above 63 returns zero, and that a register-form AND matches the operands sampled one cycle earlier. The arithmetic results, the adjust bit, the sign extension of the two immediate widths, the shift scale, zero-index reads and the boundary counts 0, 63 and 64 can only be shown by the bench. It compares each registered result with its own model over random and directed operations.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_SHLADD = 4'd2,
    OP_AND    = 4'd3,
    OP_OR     = 4'd4,
    OP_XOR    = 4'd5,
    OP_ANDCM  = 4'd6,
    OP_SHL    = 4'd7,
    OP_SHRA   = 4'd8,
    OP_SHRL   = 4'd9
  } alu_op_e;

  localparam int SHORT_IMM_W = 8;
endpackage

// File: rtl/alu_operands.sv
module alu_operands
  import int_alu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int IMM_W   = 14,
  parameter int IDX_W   = 7,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [3:0]         op,
  input  logic               use_imm,
  input  logic [IMM_W-1:0]   imm,
  input  logic [IDX_W-1:0]   a_idx,
  input  logic [DATA_W-1:0]  a_val,
  input  logic [IDX_W-1:0]   b_idx,
  input  logic [DATA_W-1:0]  b_val,
  output logic [DATA_W-1:0]  opnd_a,
  output logic [DATA_W-1:0]  opnd_b,
  output logic [DATA_W-1:0]  shift_src,
  output logic [SHAMT_W-1:0] shamt,
  output logic               shamt_ovf
);
  logic [DATA_W-1:0] a_reg, b_reg, imm_long, imm_short;

  // index zero is the hardwired zero register
  assign a_reg = (a_idx == '0) ? '0 : a_val;
  assign b_reg = (b_idx == '0) ? '0 : b_val;

  assign imm_long  = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign imm_short = {{(DATA_W-SHORT_IMM_W){imm[SHORT_IMM_W-1]}}, imm[SHORT_IMM_W-1:0]};

  always_comb begin
    opnd_a = a_reg;
    if (use_imm) begin
      unique case (op)
        OP_ADD:                                  opnd_a = imm_long;
        OP_SUB, OP_AND, OP_OR, OP_XOR, OP_ANDCM: opnd_a = imm_short;
        default:                                 opnd_a = a_reg;
      endcase
    end
  end

  assign opnd_b    = b_reg;
  assign shift_src = a_reg;
  assign shamt     = use_imm ? imm[SHAMT_W-1:0] : b_reg[SHAMT_W-1:0];
  assign shamt_ovf = !use_imm && (|b_reg[DATA_W-1:SHAMT_W]);
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
  import int_alu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SCALE_W = 2
) (
  input  logic [3:0]         op,
  input  logic               adj,
  input  logic [SCALE_W-1:0] scale,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  output logic [DATA_W-1:0]  sum
);
  logic              is_sub, is_scaled, cin;
  logic [SCALE_W:0]  shift_by;
  logic [DATA_W-1:0] a_eff, b_eff;

  assign is_sub    = (op == OP_SUB);
  assign is_scaled = (op == OP_SHLADD);
  assign shift_by  = {1'b0, scale} + 1'b1;
  assign a_eff     = is_scaled ? (a << shift_by) : a;
  assign b_eff     = is_sub ? ~b : b;
  // a-b = a+~b+1, a-b-1 = a+~b ; a+b+1 uses the carry in
  assign cin       = is_scaled ? 1'b0 : (is_sub ^ adj);
  assign sum       = a_eff + b_eff + {{(DATA_W-1){1'b0}}, cin};
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W  = 64,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  value,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic               ovf,
  input  logic               dir_left,
  input  logic               arith,
  output logic [DATA_W-1:0]  result
);
  logic [DATA_W-1:0] rev_in, rev_out, rshift;
  logic [DATA_W-1:0] stage [0:SHAMT_W];
  logic              fill;

  assign fill = arith && !dir_left && value[DATA_W-1];

  // left shifts reuse the right-shift stages on bit-reversed data
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev_in[i]  = value[DATA_W-1-i];
    assign rev_out[i] = rshift[DATA_W-1-i];
  end

  assign stage[0] = dir_left ? rev_in : value;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = shamt[k] ? {{STEP{fill}}, stage[k][DATA_W-1:STEP]} : stage[k];
  end

  assign rshift = stage[SHAMT_W];
  assign result = ovf ? {DATA_W{fill}} : (dir_left ? rev_out : rshift);
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_alu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int IMM_W   = 14,
  parameter int IDX_W   = 7,
  parameter int SCALE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_qp,
  input  logic [3:0]         in_op,
  input  logic               in_adj,
  input  logic               in_use_imm,
  input  logic [IMM_W-1:0]   in_imm,
  input  logic [SCALE_W-1:0] in_scale,
  input  logic [IDX_W-1:0]   in_a_idx,
  input  logic [DATA_W-1:0]  in_a_val,
  input  logic [IDX_W-1:0]   in_b_idx,
  input  logic [DATA_W-1:0]  in_b_val,
  input  logic [IDX_W-1:0]   in_dst_idx,
  output logic               out_wr_en,
  output logic [IDX_W-1:0]   out_wr_idx,
  output logic [DATA_W-1:0]  out_wr_data
);
  localparam int SHAMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0]  opnd_a, opnd_b, shift_src, sum, shifted, result;
  logic [SHAMT_W-1:0] shamt;
  logic               shamt_ovf, op_known, do_write;

  alu_operands #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_opnd (
    .op(in_op), .use_imm(in_use_imm), .imm(in_imm),
    .a_idx(in_a_idx), .a_val(in_a_val), .b_idx(in_b_idx), .b_val(in_b_val),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .shift_src(shift_src),
    .shamt(shamt), .shamt_ovf(shamt_ovf)
  );

  alu_addsub #(.DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_addsub (
    .op(in_op), .adj(in_adj), .scale(in_scale),
    .a(opnd_a), .b(opnd_b), .sum(sum)
  );

  alu_shifter #(.DATA_W(DATA_W)) u_shift (
    .value(shift_src), .shamt(shamt), .ovf(shamt_ovf),
    .dir_left(in_op == OP_SHL), .arith(in_op == OP_SHRA),
    .result(shifted)
  );

  always_comb begin
    op_known = 1'b1;
    result   = '0;
    unique case (in_op)
      OP_ADD, OP_SUB, OP_SHLADD: result = sum;
      OP_AND:                    result = opnd_a & opnd_b;
      OP_OR:                     result = opnd_a | opnd_b;
      OP_XOR:                    result = opnd_a ^ opnd_b;
      OP_ANDCM:                  result = opnd_a & ~opnd_b;
      OP_SHL, OP_SHRA, OP_SHRL:  result = shifted;
      default:                   op_known = 1'b0;
    endcase
  end

  assign do_write = in_valid && in_qp && op_known && (in_dst_idx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_wr_en   <= 1'b0;
      out_wr_idx  <= '0;
      out_wr_data <= '0;
    end else begin
      out_wr_en <= do_write;
      if (do_write) begin
        out_wr_idx  <= in_dst_idx;
        out_wr_data <= result;
      end
    end
  end
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int DATA_W  = 64,
  parameter int IMM_W   = 14,
  parameter int IDX_W   = 7,
  parameter int SCALE_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_qp,
  input logic [3:0]         in_op,
  input logic               in_adj,
  input logic               in_use_imm,
  input logic [IMM_W-1:0]   in_imm,
  input logic [SCALE_W-1:0] in_scale,
  input logic [IDX_W-1:0]   in_a_idx,
  input logic [DATA_W-1:0]  in_a_val,
  input logic [IDX_W-1:0]   in_b_idx,
  input logic [DATA_W-1:0]  in_b_val,
  input logic [IDX_W-1:0]   in_dst_idx,
  input logic               out_wr_en,
  input logic [IDX_W-1:0]   out_wr_idx,
  input logic [DATA_W-1:0]  out_wr_data
);
  localparam int SHAMT_W = $clog2(DATA_W);

  logic big_count;
  logic plain_issue;
  assign big_count   = (in_b_idx != '0) && (|in_b_val[DATA_W-1:SHAMT_W]) && !in_use_imm;
  assign plain_issue = in_valid && in_qp && (in_dst_idx != '0);

  p_pred_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || !in_qp) |=> !out_wr_en);

  p_no_dst_zero_r9: assert property (@(posedge clk) disable iff (rst)
    out_wr_en |-> (out_wr_idx != '0));

  p_shl_saturate_r6: assert property (@(posedge clk) disable iff (rst)
    (plain_issue && in_op == 4'd7 && big_count) |=> (out_wr_en && out_wr_data == '0));

  p_shrl_saturate_r7: assert property (@(posedge clk) disable iff (rst)
    (plain_issue && in_op == 4'd9 && big_count) |=> (out_wr_en && out_wr_data == '0));

  p_and_reg_r5: assert property (@(posedge clk) disable iff (rst)
    (plain_issue && in_op == 4'd3 && !in_use_imm && in_a_idx != '0 && in_b_idx != '0)
      |=> (out_wr_data == ($past(in_a_val) & $past(in_b_val))));

  p_dst_follow_r10: assert property (@(posedge clk) disable iff (rst)
    (plain_issue && in_op == 4'd4) |=> (out_wr_en && out_wr_idx == $past(in_dst_idx)));
endmodule

bind int_exec_unit int_exec_unit_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W), .SCALE_W(SCALE_W)
) u_chk (.*);

// File: tb/tb_int_exec_unit.sv
`timescale 1ns/1ps
module tb_int_exec_unit;
  localparam int DATA_W  = 64;
  localparam int IMM_W   = 14;
  localparam int IDX_W   = 7;
  localparam int SCALE_W = 2;
  localparam real PERIOD = 20.0;

  logic               clk = 1'b0;
  logic               rst;
  logic               in_valid, in_qp, in_adj, in_use_imm;
  logic [3:0]         in_op;
  logic [IMM_W-1:0]   in_imm;
  logic [SCALE_W-1:0] in_scale;
  logic [IDX_W-1:0]   in_a_idx, in_b_idx, in_dst_idx;
  logic [DATA_W-1:0]  in_a_val, in_b_val;
  logic               out_wr_en;
  logic [IDX_W-1:0]   out_wr_idx;
  logic [DATA_W-1:0]  out_wr_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  int_exec_unit #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W), .SCALE_W(SCALE_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_qp(in_qp), .in_op(in_op),
    .in_adj(in_adj), .in_use_imm(in_use_imm), .in_imm(in_imm), .in_scale(in_scale),
    .in_a_idx(in_a_idx), .in_a_val(in_a_val), .in_b_idx(in_b_idx), .in_b_val(in_b_val),
    .in_dst_idx(in_dst_idx), .out_wr_en(out_wr_en), .out_wr_idx(out_wr_idx),
    .out_wr_data(out_wr_data)
  );

  function automatic logic [63:0] sx14(input logic [13:0] v);
    return {{50{v[13]}}, v};
  endfunction
  function automatic logic [63:0] sx8(input logic [13:0] v);
    return {{56{v[7]}}, v[7:0]};
  endfunction

  function automatic logic [63:0] model(input logic [3:0] op, input logic adj, input logic ui,
      input logic [13:0] imm, input logic [1:0] sc, input logic [63:0] ra, input logic [63:0] rb);
    logic [63:0] cnt;
    cnt = ui ? {58'd0, imm[5:0]} : rb;
    case (op)
      4'd0: return (ui ? sx14(imm) : ra) + rb + (adj ? 64'd1 : 64'd0);
      4'd1: return (ui ? sx8(imm) : ra) - rb - (adj ? 64'd1 : 64'd0);
      4'd2: return (ra << (sc + 1)) + rb;
      4'd3: return (ui ? sx8(imm) : ra) & rb;
      4'd4: return (ui ? sx8(imm) : ra) | rb;
      4'd5: return (ui ? sx8(imm) : ra) ^ rb;
      4'd6: return (ui ? sx8(imm) : ra) & ~rb;
      4'd7: return (cnt > 63) ? 64'd0 : (ra << cnt);
      4'd8: return (cnt > 63) ? {64{ra[63]}} : 64'($signed(ra) >>> cnt);
      4'd9: return (cnt > 63) ? 64'd0 : (ra >> cnt);
      default: return 64'd0;
    endcase
  endfunction

  function automatic string op_req(input logic [3:0] op);
    case (op)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3, 4'd4, 4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, result is registered at the next rising edge,
  // and sampled at the falling edge after it
  task automatic run_op(input string req, input logic v, input logic qp, input logic [3:0] op,
      input logic adj, input logic ui, input logic [13:0] imm, input logic [1:0] sc,
      input logic [6:0] ai, input logic [63:0] av, input logic [6:0] bi, input logic [63:0] bv,
      input logic [6:0] di);
    logic [63:0] ra, rb, exp;
    logic        exp_en;
    @(negedge clk);
    in_valid = v; in_qp = qp; in_op = op; in_adj = adj; in_use_imm = ui; in_imm = imm;
    in_scale = sc; in_a_idx = ai; in_a_val = av; in_b_idx = bi; in_b_val = bv; in_dst_idx = di;
    ra = (ai == 0) ? 64'd0 : av;
    rb = (bi == 0) ? 64'd0 : bv;
    exp    = model(op, adj, ui, imm, sc, ra, rb);
    exp_en = v && qp && (op <= 4'd9) && (di != 0);
    @(negedge clk);
    check(req, {63'd0, out_wr_en}, {63'd0, exp_en});
    if (exp_en) begin
      check(req, out_wr_data, exp);
      check(req, {57'd0, out_wr_idx}, {57'd0, di});
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; in_valid = 0; in_qp = 0; in_op = 0; in_adj = 0; in_use_imm = 0;
    in_imm = 0; in_scale = 0; in_a_idx = 0; in_a_val = 0; in_b_idx = 0; in_b_val = 0;
    in_dst_idx = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {63'd0, out_wr_en}, 64'd0);
    check("R1", out_wr_data, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // R2 add forms
    run_op("R2", 1, 1, 4'd0, 0, 0, 0, 0, 7'd5, 64'd100, 7'd6, 64'd23, 7'd9);
    run_op("R2", 1, 1, 4'd0, 1, 0, 0, 0, 7'd5, 64'hFFFF_FFFF_FFFF_FFFF, 7'd6, 64'd0, 7'd9);
    run_op("R2", 1, 1, 4'd0, 0, 1, 14'h2000, 0, 7'd5, 64'd7, 7'd6, 64'd10000, 7'd9);
    // R3 subtract forms, upper immediate bits ignored
    run_op("R3", 1, 1, 4'd1, 1, 0, 0, 0, 7'd5, 64'd50, 7'd6, 64'd8, 7'd3);
    run_op("R3", 1, 1, 4'd1, 0, 1, 14'h3F80, 0, 7'd5, 64'd0, 7'd6, 64'd2, 7'd3);
    run_op("R3", 1, 1, 4'd1, 0, 1, 14'h0080, 0, 7'd5, 64'd0, 7'd6, 64'd2, 7'd3);
    // R4 scaled add, adjust and immediate select have no effect
    run_op("R4", 1, 1, 4'd2, 1, 1, 14'h1FFF, 2'd3, 7'd1, 64'h0F, 7'd2, 64'd1, 7'd4);
    run_op("R4", 1, 1, 4'd2, 0, 0, 0, 2'd0, 7'd1, 64'h8000_0000_0000_0003, 7'd2, 64'd1, 7'd4);
    // R5 and-complement, register and immediate
    run_op("R5", 1, 1, 4'd6, 0, 0, 0, 0, 7'd8, 64'hFF00_FF00_FF00_FF00, 7'd9, 64'hF0F0_F0F0_F0F0_F0F0, 7'd10);
    run_op("R5", 1, 1, 4'd6, 0, 1, 14'h00F0, 0, 7'd8, 64'd0, 7'd9, 64'h0000_0000_0000_0030, 7'd10);
    // R6 left shift edges
    run_op("R6", 1, 1, 4'd7, 0, 0, 0, 0, 7'd1, 64'd1, 7'd2, 64'd63, 7'd11);
    run_op("R6", 1, 1, 4'd7, 0, 0, 0, 0, 7'd1, 64'hFFFF, 7'd2, 64'd64, 7'd11);
    run_op("R6", 1, 1, 4'd7, 0, 1, 14'h3FFF, 0, 7'd1, 64'd3, 7'd2, 64'd0, 7'd11);
    // R7 right shift edges
    run_op("R7", 1, 1, 4'd8, 0, 0, 0, 0, 7'd1, 64'h8000_0000_0000_0000, 7'd2, 64'd100, 7'd12);
    run_op("R7", 1, 1, 4'd8, 0, 0, 0, 0, 7'd1, 64'h8000_0000_0000_0010, 7'd2, 64'd0, 7'd12);
    run_op("R7", 1, 1, 4'd8, 0, 1, 14'h0004, 0, 7'd1, 64'hF000_0000_0000_0000, 7'd2, 64'd0, 7'd12);
    run_op("R7", 1, 1, 4'd9, 0, 0, 0, 0, 7'd1, 64'hFFFF_FFFF_FFFF_FFFF, 7'd2, 64'd64, 7'd12);
    run_op("R7", 1, 1, 4'd9, 0, 0, 0, 0, 7'd1, 64'hFFFF_FFFF_FFFF_FFFF, 7'd2, 64'd63, 7'd12);
    // R8 predicate gating and unknown op codes
    run_op("R8", 1, 0, 4'd0, 0, 0, 0, 0, 7'd1, 64'd1, 7'd2, 64'd1, 7'd13);
    run_op("R8", 0, 1, 4'd0, 0, 0, 0, 0, 7'd1, 64'd1, 7'd2, 64'd1, 7'd13);
    run_op("R8", 1, 1, 4'd12, 0, 0, 0, 0, 7'd1, 64'd1, 7'd2, 64'd1, 7'd13);
    // R9 zero register reads and writes
    run_op("R9", 1, 1, 4'd4, 0, 0, 0, 0, 7'd0, 64'hDEAD_BEEF, 7'd0, 64'h1234, 7'd14);
    run_op("R9", 1, 1, 4'd7, 0, 0, 0, 0, 7'd3, 64'd5, 7'd0, 64'd1000, 7'd14);
    run_op("R9", 1, 1, 4'd0, 0, 0, 0, 0, 7'd3, 64'd5, 7'd4, 64'd6, 7'd0);
    // R10 back-to-back issues land one cycle later with their own index
    run_op("R10", 1, 1, 4'd5, 0, 0, 0, 0, 7'd3, 64'hAAAA, 7'd4, 64'h5555, 7'd127);
    run_op("R10", 1, 1, 4'd3, 0, 0, 0, 0, 7'd3, 64'hAAAA, 7'd4, 64'hFFFF, 7'd1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0]  op;
      logic [63:0] bv;
      op = 4'($urandom_range(0, 10));
      bv = {$urandom(), $urandom()};
      if ($urandom_range(0, 1) == 1) bv = 64'($urandom_range(0, 70));
      run_op(op_req(op), ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0), op,
             1'($urandom()), 1'($urandom()), 14'($urandom()), 2'($urandom()),
             7'($urandom_range(0, 15)), {$urandom(), $urandom()},
             7'($urandom_range(0, 15)), bv, 7'($urandom_range(0, 31)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule